// File: doc/BRIEF.md
# Input Capture Timestamp Unit

This block timestamps edges on an external pin. It has its own counter, which advances on a clock-enable tick. The pin is brought into the clock domain and its edges are detected. A prescaler then thins them out. Each event that remains writes the current counter value into a small first-in first-out buffer. Software drains the buffer one entry at a time through a pop strobe. The oldest stamp is always shown on the read port.

The counter runs in one of four ways. It can run freely. It can be cleared by a pulse on a chosen sync line. It can be held at zero until a chosen line fires. It can be held at zero until software starts it. A five-bit source code and a trigger bit pick the way it runs.

The unit has three outputs for software:
- a not-empty flag for the buffer;
- a sticky overflow flag for captures that were dropped;
- an interrupt pulse that fires once every one to four capture events.

Top module: `capture_timestamp`

## Requirements
- R1: The 16-bit counter `timerOut` rises by one on each clock edge where `tickEn` is high and holds where it is low; it wraps from 0xFFFF to 0x0000.
- R2: `capPin` goes through two synchronizer flops. `cfgEdge` picks the edges that count: 00 none, 01 rising, 10 falling, 11 both. A pin level first sampled at edge k appears in the buffer after edge k+2. The stamp stored is the `timerOut` value held just before edge k+2.
- R3: `cfgPre` sets the prescale of detected edges: 00 keeps every edge, 01 keeps every 4th, 10 and 11 keep every 16th. The prescale count restarts while `cfgEdge` is 00.
- R4: The buffer holds four stamps and returns them oldest first. `popData` shows the oldest stamp while `notEmpty` is high. A `popReq` pulse removes that stamp on the next edge. A pop while the buffer is empty has no effect.
- R5: A capture that arrives when the buffer is full, with no pop in the same cycle, is dropped. It sets `overflow`, which stays high until an `ovfClr` pulse.
- R6: With `cfgSyncSel` = 0 and `cfgTrig` = 0 the counter runs freely, and `syncSrc` has no effect.
- R7: With `cfgSyncSel` = k (k ≠ 0) and `cfgTrig` = 0, a high on `syncSrc[k-1]` at an edge sets the counter to 0 at that edge. Counting resumes on the next edge. The other sync lines are ignored.
- R8: With `cfgSyncSel` = k (k ≠ 0) and `cfgTrig` = 1, the counter is held at 0 while `trigStat` is low. A high on `syncSrc[k-1]` sets `trigStat` at that edge, and counting starts on the next edge.
- R9: With `cfgTrig` = 1, a `swTrigSet` pulse sets `trigStat`. A `swTrigClr` pulse clears it, and clear wins over set. After the clear the counter returns to 0 on the following edge and stays there. `trigStat` is 0 whenever `cfgTrig` is 0.
- R10: `irqFlag` pulses for one cycle on every (`cfgIrqCnt`+1)-th capture event. Dropped events are counted. The pulse comes in the same cycle that the stamp becomes visible. The event count restarts while `cfgEdge` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tickEn | input | 1 | Counter advance enable |
| capPin | input | 1 | Asynchronous capture pin |
| syncSrc | input | 31 | Sync/trigger lines; code k selects bit k-1 |
| cfgEdge | input | 2 | Edge select |
| cfgPre | input | 2 | Event prescale select |
| cfgSyncSel | input | 5 | Sync/trigger source code |
| cfgTrig | input | 1 | Trigger mode bit |
| cfgIrqCnt | input | 2 | Events per interrupt, minus one |
| swTrigSet | input | 1 | Software trigger start pulse |
| swTrigClr | input | 1 | Software trigger stop pulse |
| popReq | input | 1 | Remove oldest stamp |
| ovfClr | input | 1 | Clear overflow flag |
| timerOut | output | 16 | Current counter value |
| popData | output | 16 | Oldest stored stamp |
| notEmpty | output | 1 | Buffer holds at least one stamp |
| overflow | output | 1 | Sticky dropped-capture flag |
| trigStat | output | 1 | Trigger armed and running |
| irqFlag | output | 1 | Interrupt pulse |

## Verification
Each result has a fixed delay after its stimulus:
- A pin change reaches the buffer, and any interrupt pulse, three edges after the input is driven. The stamp is the counter value seen one cycle before that.
- Sync clears, trigger sets and pops act on the first edge.
- A software stop brings the counter to zero on the second edge.

The bench drives inputs on the falling clock edge and samples outputs at the next falling edge after exactly the number of rising edges listed above. It also checks one cycle early that no stamp has appeared yet.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_HWTRIG = 2'd2,
    MODE_SWTRIG = 2'd3
  } timerMode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic timerClr;
    logic timerInc;
    logic push;
  } capStrb_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      capPin,
  input  logic [(2**SYNC_W)-2:0]    syncSrc,
  input  logic [1:0]                cfgEdge,
  input  logic [1:0]                cfgPre,
  input  logic [SYNC_W-1:0]         cfgSyncSel,
  input  logic                      cfgTrig,
  input  logic [1:0]                cfgIrqCnt,
  input  logic                      swTrigSet,
  input  logic                      swTrigClr,
  output capStrb_t                  strb,
  output logic                      trigStat,
  output logic                      irqFlag
);
  localparam int PRE_W = 4;

  logic pinMeta, pinSync, pinPrev;
  logic edgeHit, capEvt, syncHit;
  logic [PRE_W-1:0] preCnt, preLimit;
  logic [1:0] irqCnt;
  timerMode_e mode;

  // two-flop synchronizer plus history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b0;
      pinSync <= 1'b0;
      pinPrev <= 1'b0;
    end else begin
      pinMeta <= capPin;
      pinSync <= pinMeta;
      pinPrev <= pinSync;
    end
  end

  always_comb begin
    unique case (edgeMode_e'(cfgEdge))
      EDGE_RISE: edgeHit = pinSync & ~pinPrev;
      EDGE_FALL: edgeHit = ~pinSync & pinPrev;
      EDGE_BOTH: edgeHit = pinSync ^ pinPrev;
      default:   edgeHit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfgPre)
      2'b00:   preLimit = PRE_W'(0);
      2'b01:   preLimit = PRE_W'(3);
      default: preLimit = PRE_W'(15);
    endcase
  end

  assign capEvt = edgeHit && (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (edgeMode_e'(cfgEdge) == EDGE_OFF) begin
      preCnt <= '0;
    end else if (edgeHit) begin
      preCnt <= capEvt ? '0 : preCnt + PRE_W'(1);
    end
  end

  // mode decode from source code and trigger bit
  always_comb begin
    if (cfgSyncSel == '0) mode = cfgTrig ? MODE_SWTRIG : MODE_FREE;
    else                  mode = cfgTrig ? MODE_HWTRIG : MODE_SYNC;
  end

  assign syncHit = (cfgSyncSel != '0) && syncSrc[cfgSyncSel - SYNC_W'(1)];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            trigStat <= 1'b0;
    else if (!cfgTrig || swTrigClr)                       trigStat <= 1'b0;
    else if (swTrigSet || (mode == MODE_HWTRIG && syncHit)) trigStat <= 1'b1;
  end

  always_comb begin
    strb.timerClr = (mode == MODE_SYNC && syncHit) || (cfgTrig && !trigStat);
    strb.timerInc = tickEn && !strb.timerClr;
    strb.push     = capEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqCnt  <= 2'd0;
      irqFlag <= 1'b0;
    end else if (edgeMode_e'(cfgEdge) == EDGE_OFF) begin
      irqCnt  <= 2'd0;
      irqFlag <= 1'b0;
    end else if (capEvt) begin
      irqFlag <= (irqCnt == cfgIrqCnt);
      irqCnt  <= (irqCnt == cfgIrqCnt) ? 2'd0 : irqCnt + 2'd1;
    end else begin
      irqFlag <= 1'b0;
    end
  end

  // R8
  hw_trig_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HWTRIG && syncHit && !swTrigClr) |=> trigStat);

  // R9
  sw_trig_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    swTrigClr |=> !trigStat);

  // R10
  irq_after_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> $past(capEvt));
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import capt_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  capStrb_t      strb,
  input  logic          popReq,
  input  logic          ovfClr,
  output logic [TW-1:0] timerVal,
  output logic [TW-1:0] popData,
  output logic          notEmpty,
  output logic          overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, doPush, doPop, dropped;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerVal <= '0;
    else if (strb.timerClr) timerVal <= '0;
    else if (strb.timerInc) timerVal <= timerVal + TW'(1);
  end

  assign full    = (count == CNT_W'(DEPTH));
  assign doPop   = popReq && (count != '0);
  assign doPush  = strb.push && (!full || doPop);
  assign dropped = strb.push && !doPush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= timerVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       overflow <= 1'b0;
    else if (dropped) overflow <= 1'b1;
    else if (ovfClr)  overflow <= 1'b0;
  end

  assign popData  = mem[rdPtr];
  assign notEmpty = (count != '0);

  // R7
  timer_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.timerClr |=> (timerVal == '0));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full && !popReq) |=> overflow);

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/capture_timestamp.sv
module capture_timestamp
  import capt_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DEPTH  = 4,
  parameter int SYNC_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   capPin,
  input  logic [(2**SYNC_W)-2:0] syncSrc,
  input  logic [1:0]             cfgEdge,
  input  logic [1:0]             cfgPre,
  input  logic [SYNC_W-1:0]      cfgSyncSel,
  input  logic                   cfgTrig,
  input  logic [1:0]             cfgIrqCnt,
  input  logic                   swTrigSet,
  input  logic                   swTrigClr,
  input  logic                   popReq,
  input  logic                   ovfClr,
  output logic [TW-1:0]          timerOut,
  output logic [TW-1:0]          popData,
  output logic                   notEmpty,
  output logic                   overflow,
  output logic                   trigStat,
  output logic                   irqFlag
);
  capStrb_t strb;

  cap_ctrl #(.SYNC_W(SYNC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capPin(capPin),
    .syncSrc(syncSrc), .cfgEdge(cfgEdge), .cfgPre(cfgPre),
    .cfgSyncSel(cfgSyncSel), .cfgTrig(cfgTrig), .cfgIrqCnt(cfgIrqCnt),
    .swTrigSet(swTrigSet), .swTrigClr(swTrigClr),
    .strb(strb), .trigStat(trigStat), .irqFlag(irqFlag)
  );

  cap_datapath #(.TW(TW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .popReq(popReq), .ovfClr(ovfClr),
    .timerVal(timerOut), .popData(popData), .notEmpty(notEmpty),
    .overflow(overflow)
  );
endmodule

// File: tb/capture_timestamp_tb.sv
`timescale 1ns/1ps
module capture_timestamp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, capPin = 1'b0;
  logic [30:0] syncSrc = '0;
  logic [1:0] cfgEdge = 2'b00, cfgPre = 2'b00, cfgIrqCnt = 2'b00;
  logic [4:0] cfgSyncSel = '0;
  logic cfgTrig = 1'b0, swTrigSet = 1'b0, swTrigClr = 1'b0;
  logic popReq = 1'b0, ovfClr = 1'b0;
  logic [15:0] timerOut, popData;
  logic notEmpty, overflow, trigStat, irqFlag;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;

  always #4 clk = ~clk;

  capture_timestamp u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capPin(capPin), .syncSrc(syncSrc),
    .cfgEdge(cfgEdge), .cfgPre(cfgPre), .cfgSyncSel(cfgSyncSel), .cfgTrig(cfgTrig),
    .cfgIrqCnt(cfgIrqCnt), .swTrigSet(swTrigSet), .swTrigClr(swTrigClr),
    .popReq(popReq), .ovfClr(ovfClr), .timerOut(timerOut), .popData(popData),
    .notEmpty(notEmpty), .overflow(overflow), .trigStat(trigStat), .irqFlag(irqFlag)
  );

  always @(negedge clk) if (rstN && irqFlag) irqSeen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      capPin = 1'b1; cyc(3);
      capPin = 1'b0; cyc(3);
    end
  endtask

  task automatic drain(output int n, output int first, output bit ordered);
    int prev;
    n = 0; first = -1; ordered = 1'b1; prev = 0;
    while (notEmpty) begin
      if (n == 0) first = popData;
      else if (popData <= prev) ordered = 1'b0;
      prev = popData;
      popReq = 1'b1; @(posedge clk); @(negedge clk);
      popReq = 1'b0;
      n++;
    end
  endtask

  // edge[13:12] pre[11:10] pulses[9:4] expected captures[3:0]
  localparam logic [13:0] VEC [8] = '{
    {2'b01, 2'b00, 6'd3,  4'd3},
    {2'b10, 2'b00, 6'd2,  4'd2},
    {2'b11, 2'b00, 6'd2,  4'd4},
    {2'b01, 2'b01, 6'd8,  4'd2},
    {2'b11, 2'b01, 6'd6,  4'd3},
    {2'b01, 2'b10, 6'd16, 4'd1},
    {2'b10, 2'b11, 6'd15, 4'd0},
    {2'b00, 2'b00, 6'd3,  4'd0}
  };

  initial begin
    cyc(190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, first, v, irq0;
    bit ordered;
    cyc(3);
    // reset state
    chk(timerOut == 0 && !notEmpty && !overflow && !trigStat && !irqFlag,
        "R1 reset", timerOut, 0);
    rstN = 1'b1;
    cyc(2);
    // R1 hold while tick low
    chk(timerOut == 0, "R1 hold", timerOut, 0);
    tickEn = 1'b1;
    cyc(7);
    chk(timerOut == 7, "R1 count", timerOut, 7);

    // R2/R3 edge and prescale table
    for (int i = 0; i < 8; i++) begin
      cfgEdge = 2'b00; capPin = 1'b0; cyc(4);
      drain(n, first, ordered);
      cfgPre = VEC[i][11:10]; cfgEdge = VEC[i][13:12]; cyc(2);
      pulses(int'(VEC[i][9:4]));
      cyc(4);
      drain(n, first, ordered);
      chk(n == int'(VEC[i][3:0]), "R2/R3 vector count", n, int'(VEC[i][3:0]));
      chk(!overflow, "R5 no overflow", overflow, 0);
    end

    // R2 stamp value and latency
    cfgEdge = 2'b01; cfgPre = 2'b00; cyc(2);
    capPin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!notEmpty, "R2 not yet visible", notEmpty, 0);
    v = timerOut;
    @(posedge clk); @(negedge clk);
    chk(notEmpty && popData == v, "R2 stamp", popData, v);
    capPin = 1'b0; cyc(3);
    drain(n, first, ordered);

    // R4 pop on empty ignored
    popReq = 1'b1; cyc(1); popReq = 1'b0;
    chk(!notEmpty, "R4 empty pop", notEmpty, 0);
    pulses(1); cyc(3);
    drain(n, first, ordered);
    chk(n == 1, "R4 count after empty pop", n, 1);

    // R5 overflow and R4 order
    pulses(5); cyc(3);
    chk(overflow, "R5 overflow set", overflow, 1);
    drain(n, first, ordered);
    chk(n == 4, "R4 depth", n, 4);
    chk(ordered, "R4 oldest first", ordered, 1);
    chk(overflow, "R5 sticky", overflow, 1);
    ovfClr = 1'b1; cyc(1); ovfClr = 1'b0;
    chk(!overflow, "R5 cleared", overflow, 0);

    // R10 interrupt every third event
    cfgEdge = 2'b00; cyc(2);
    cfgIrqCnt = 2'd2; cfgEdge = 2'b01; cyc(2);
    irq0 = irqSeen;
    pulses(2); cyc(4);
    chk(irqSeen - irq0 == 0, "R10 no irq early", irqSeen - irq0, 0);
    pulses(4); cyc(4);
    chk(irqSeen - irq0 == 2, "R10 irq count", irqSeen - irq0, 2);
    drain(n, first, ordered);
    cfgEdge = 2'b00;

    // R6 free-run ignores sync lines
    v = timerOut;
    syncSrc = '1; cyc(1); syncSrc = '0;
    chk(timerOut == ((v + 1) & 16'hFFFF), "R6 sync ignored", timerOut, v + 1);

    // R7 synchronous mode, source 3 -> line 2
    cfgSyncSel = 5'd3; cyc(3);
    syncSrc[0] = 1'b1; v = timerOut; cyc(1); syncSrc[0] = 1'b0;
    chk(timerOut == ((v + 1) & 16'hFFFF), "R7 other line ignored", timerOut, v + 1);
    syncSrc[2] = 1'b1; cyc(1); syncSrc[2] = 1'b0;
    chk(timerOut == 0, "R7 sync clear", timerOut, 0);
    cyc(1);
    chk(timerOut == 1, "R7 resume", timerOut, 1);

    // R8 hardware trigger
    cfgTrig = 1'b1; cyc(3);
    chk(timerOut == 0 && !trigStat, "R8 held", timerOut, 0);
    syncSrc[2] = 1'b1; cyc(1); syncSrc[2] = 1'b0;
    chk(trigStat && timerOut == 0, "R8 armed", trigStat, 1);
    cyc(5);
    chk(timerOut == 5, "R8 running", timerOut, 5);

    // R9 software stop then software start
    swTrigClr = 1'b1; cyc(1); swTrigClr = 1'b0;
    chk(!trigStat, "R9 stat cleared", trigStat, 0);
    cyc(1);
    chk(timerOut == 0, "R9 stopped", timerOut, 0);
    cyc(3);
    chk(timerOut == 0, "R9 stays", timerOut, 0);
    cfgSyncSel = 5'd0; cyc(1);
    swTrigSet = 1'b1; cyc(1); swTrigSet = 1'b0;
    chk(trigStat, "R9 sw start", trigStat, 1);
    cyc(4);
    chk(timerOut == 4, "R9 sw running", timerOut, 4);
    cfgTrig = 1'b0; cyc(1);
    chk(!trigStat, "R9 stat off", trigStat, 0);

    // R1 hold and wrap
    tickEn = 1'b0; v = timerOut; cyc(5);
    chk(timerOut == v, "R1 hold tick low", timerOut, v);
    tickEn = 1'b1; cyc(65536);
    chk(timerOut == v, "R1 wrap", timerOut, v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule